// File: doc/BRIEF.md
# Paged Processor Access Port for a Time-Slot Switch

This block is the microprocessor side of a time-slot switching core. A host drives a six-bit address, an 8-bit write value and single-cycle read and write strobes. The block sends each access to one of four targets: its own 8-bit control register, the per-stream data memory, or the low or high connection memory bank. The memory arrays are outside the block. It drives their shared address and write data and a write enable for each connection bank, and it selects the returned read data.

The control register picks a page: one memory type and one stream. The 32 channel locations of that stream then show up as a window that the host addresses directly. In split mode, reads always return data memory contents while writes go to a connection bank. This lets the host watch live samples and program connections without rewriting the register between accesses. The processor-mode bit is exported to the switching core as a global override.

The access sequencer has two states. S_IDLE accepts strobes. The transition IDLE_TO_FETCH is taken when a read is accepted. S_FETCH waits the one cycle the synchronous memories need. The transition FETCH_TO_IDLE is always taken and registers the read result.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset the control register is 0x00, `cpu_rdata` is 0x00, `cpu_rvalid` is 0 and `proc_mode` is 0.
- R2: A write with address bit 5 low loads the control register. Address bits 4..0 are ignored. The register layout is: bit 7 split, bit 6 processor mode, bit 5 spare, bits 4..3 memory select, bits 2..0 stream. A control read returns the register with bit 5 always 0.
- R3: `proc_mode` equals control bit 6 from the cycle after the control write.
- R4: During a paged access (address bit 5 high), `mem_addr` equals {stream, address bits 4..0}.
- R5: Without split mode, a paged read returns the location selected by memory select: 01 data memory, 10 connection low, 11 connection high. `cpu_rvalid` pulses high, with `cpu_rdata` valid, in the second cycle after the strobe cycle.
- R6: Without split mode, a paged write with select 10 or 11 writes `cpu_wdata` into the low or high connection bank. A write with select 01 (data memory) writes nothing.
- R7: With memory select 00 and no split mode, a paged read returns 0x00 and a paged write writes nothing.
- R8: With split mode set, every paged read returns data memory contents, whatever memory select holds.
- R9: With split mode set, a paged write goes to the high bank when select is 11 and to the low bank otherwise.
- R10: A read and write strobed together act as the write alone, with no `cpu_rvalid`. Strobes given during S_FETCH are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 6 | Host address; bit 5 selects page window vs control register |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 8 | Host write value |
| cpu_rdata | output | 8 | Registered read result |
| cpu_rvalid | output | 1 | One-cycle pulse marking `cpu_rdata` valid |
| mem_addr | output | 8 | {stream, channel} address to all three memories |
| mem_wdata | output | 8 | Write value to the connection banks |
| cml_we | output | 1 | Connection low bank write enable |
| cmh_we | output | 1 | Connection high bank write enable |
| dm_rdata | input | 8 | Data memory read value, one cycle after address |
| cml_rdata | input | 8 | Connection low read value, one cycle after address |
| cmh_rdata | input | 8 | Connection high read value, one cycle after address |
| proc_mode | output | 1 | Global processor-mode override to the switching core |

## Verification
The hardest case to reach is split mode with a non-connection memory select. A write then has to land in the low bank. This is seen only by leaving split mode later and reading the low bank back. The bench programs split mode with select 01, writes a channel, reprograms the register to select 10 without split, and reads that channel. Ignored strobes during S_FETCH are reached by issuing a control write on the cycle right after a read strobe, then reading the register back.

// File: rtl/tsi_cpu_pkg.sv
package tsi_cpu_pkg;
    localparam int STREAM_W = 3;
    localparam int CHAN_W   = 5;
    localparam int DATA_W   = 8;
    localparam int MADDR_W  = STREAM_W + CHAN_W;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_DM   = 2'b01,
        SEL_CML  = 2'b10,
        SEL_CMH  = 2'b11
    } msel_t;

    typedef struct packed {
        logic                split;
        logic                pmode;
        logic                spare;
        msel_t               msel;
        logic [STREAM_W-1:0] stream;
    } ctrl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_DM,
        TGT_CML,
        TGT_CMH
    } tgt_t;

    typedef enum logic {
        S_IDLE,
        S_FETCH
    } st_t;
endpackage

// File: rtl/tsi_cpu_ctrl_reg.sv
module tsi_cpu_ctrl_reg
    import tsi_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (load) begin
            ctrl_q       <= ctrl_t'(wdata);
            ctrl_q.spare <= 1'b0;
        end
    end

    assign ctrl = ctrl_q;

    // R2
    ctrl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctrl.spare == 1'b0));
endmodule

// File: rtl/tsi_cpu_decode.sv
module tsi_cpu_decode
    import tsi_cpu_pkg::*;
(
    input  logic  paged,
    input  ctrl_t ctrl,
    output tgt_t  rd_tgt,
    output tgt_t  wr_tgt
);
    always_comb begin
        if (!paged) begin
            rd_tgt = TGT_CTRL;
            wr_tgt = TGT_CTRL;
        end else if (ctrl.split) begin
            rd_tgt = TGT_DM;
            wr_tgt = (ctrl.msel == SEL_CMH) ? TGT_CMH : TGT_CML;
        end else begin
            unique case (ctrl.msel)
                SEL_DM:  begin rd_tgt = TGT_DM;   wr_tgt = TGT_NONE; end
                SEL_CML: begin rd_tgt = TGT_CML;  wr_tgt = TGT_CML;  end
                SEL_CMH: begin rd_tgt = TGT_CMH;  wr_tgt = TGT_CMH;  end
                default: begin rd_tgt = TGT_NONE; wr_tgt = TGT_NONE; end
            endcase
        end
    end
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
    import tsi_cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHAN_W:0]     cpu_addr,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_rvalid,
    output logic [MADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                cml_we,
    output logic                cmh_we,
    input  logic [DATA_W-1:0]   dm_rdata,
    input  logic [DATA_W-1:0]   cml_rdata,
    input  logic [DATA_W-1:0]   cmh_rdata,
    output logic                proc_mode
);
    st_t   state_q, state_d;
    tgt_t  tgt_q;
    tgt_t  rd_tgt, wr_tgt;
    ctrl_t ctrl;
    logic  paged, wr_go, rd_go;
    logic [DATA_W-1:0] rd_mux;

    assign paged = cpu_addr[CHAN_W];
    assign wr_go = (state_q == S_IDLE) && cpu_wr;
    assign rd_go = (state_q == S_IDLE) && cpu_rd && !cpu_wr;

    tsi_cpu_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_go && !paged),
        .wdata (cpu_wdata),
        .ctrl  (ctrl)
    );

    tsi_cpu_decode u_dec (
        .paged  (paged),
        .ctrl   (ctrl),
        .rd_tgt (rd_tgt),
        .wr_tgt (wr_tgt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tgt_q   <= TGT_NONE;
        end else begin
            state_q <= state_d;
            if (rd_go) tgt_q <= rd_tgt;
        end
    end

    // next state: IDLE_TO_FETCH on accepted read, FETCH_TO_IDLE always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (rd_go) state_d = S_FETCH;
            S_FETCH: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (tgt_q)
            TGT_CTRL: rd_mux = ctrl;
            TGT_DM:   rd_mux = dm_rdata;
            TGT_CML:  rd_mux = cml_rdata;
            TGT_CMH:  rd_mux = cmh_rdata;
            default:  rd_mux = '0;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata  <= '0;
            cpu_rvalid <= 1'b0;
        end else begin
            cpu_rvalid <= (state_q == S_FETCH);
            if (state_q == S_FETCH) cpu_rdata <= rd_mux;
        end
    end

    assign mem_addr  = {ctrl.stream, cpu_addr[CHAN_W-1:0]};
    assign mem_wdata = cpu_wdata;
    assign cml_we    = wr_go && paged && (wr_tgt == TGT_CML);
    assign cmh_we    = wr_go && paged && (wr_tgt == TGT_CMH);
    assign proc_mode = ctrl.pmode;

    // R6
    bank_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cml_we, cmh_we}));

    // R6
    we_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cml_we || cmh_we) |-> (cpu_wr && cpu_addr[CHAN_W]));

    // R10
    read_enters_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cpu_rd && !cpu_wr) |=> (state_q == S_FETCH));

    // R5
    rvalid_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH) |=> cpu_rvalid);

    // R10
    fetch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH) |-> !(cml_we || cmh_we));
endmodule

// File: tb/test_tsi_cpu_port.sv
module test_tsi_cpu_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_rvalid;
    logic [7:0] mem_addr, mem_wdata;
    logic       cml_we, cmh_we, proc_mode;
    logic [7:0] dm_rdata, cml_rdata, cmh_rdata;

    logic [7:0] dm_m [256];
    logic [7:0] cml_m [256];
    logic [7:0] cmh_m [256];

    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    tsi_cpu_port i_tsi_cpu_port (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cml_we(cml_we), .cmh_we(cmh_we), .dm_rdata(dm_rdata),
        .cml_rdata(cml_rdata), .cmh_rdata(cmh_rdata), .proc_mode(proc_mode)
    );

    function automatic logic [7:0] dm_init(int i);  return 8'(i) ^ 8'h5A; endfunction
    function automatic logic [7:0] cml_init(int i); return 8'(i + 3);     endfunction
    function automatic logic [7:0] cmh_init(int i); return ~8'(i);        endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            dm_m[i] = dm_init(i); cml_m[i] = cml_init(i); cmh_m[i] = cmh_init(i);
        end
    end

    always @(posedge clk) begin
        dm_rdata  <= dm_m[mem_addr];
        cml_rdata <= cml_m[mem_addr];
        cmh_rdata <= cmh_m[mem_addr];
        if (cml_we) cml_m[mem_addr] <= mem_wdata;
        if (cmh_we) cmh_m[mem_addr] <= mem_wdata;
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic [5:0] a, logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(logic [5:0] a, output logic [7:0] d, output logic v);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0;
        @(posedge clk); #1;
        d = cpu_rdata; v = cpu_rvalid;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic v;
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 rvalid", {7'b0, cpu_rvalid}, 8'h00);
        check("R1 proc_mode", {7'b0, proc_mode}, 8'h00);
        cpu_read(6'h00, d, v);
        check("R1 ctrl", d, 8'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] d; logic v;
        cpu_write(6'h1F, 8'hFF);
        #1 check("R3 proc_mode set", {7'b0, proc_mode}, 8'h01);
        cpu_read(6'h0A, d, v);
        check("R2 ctrl readback bit5 zero", d, 8'hDF);
        check("R5 rvalid on ctrl read", {7'b0, v}, 8'h01);
        cpu_write(6'h00, 8'h2B);
        #1 check("R3 proc_mode clear", {7'b0, proc_mode}, 8'h00);
        cpu_read(6'h15, d, v);
        check("R2 ctrl readback", d, 8'h0B);
    endtask

    task automatic t_paged_read();
        logic [7:0] d; logic v;
        cpu_write(6'h00, 8'h0B);            // sel 01 stream 3
        @(negedge clk); cpu_addr = 6'h27; #1;
        check("R4 mem_addr", mem_addr, 8'h67);
        cpu_read(6'h27, d, v);
        check("R5 dm read", d, dm_init(3*32+7));
        check("R5 rvalid", {7'b0, v}, 8'h01);
        @(posedge clk); #1 check("R5 rvalid one cycle", {7'b0, cpu_rvalid}, 8'h00);
        cpu_write(6'h00, 8'h15);            // sel 10 stream 5
        cpu_read(6'h3F, d, v);
        check("R5 cml read", d, cml_init(5*32+31));
        cpu_write(6'h00, 8'h18);            // sel 11 stream 0
        cpu_read(6'h20, d, v);
        check("R5 cmh read", d, cmh_init(0));
    endtask

    task automatic t_paged_write();
        logic [7:0] d; logic v;
        cpu_write(6'h00, 8'h15);
        cpu_write(6'h24, 8'hA5);
        cpu_read(6'h24, d, v);
        check("R6 cml write", d, 8'hA5);
        cpu_write(6'h00, 8'h1D);            // sel 11 stream 5
        cpu_read(6'h24, d, v);
        check("R6 cmh untouched", d, cmh_init(5*32+4));
        cpu_write(6'h24, 8'h3C);
        cpu_read(6'h24, d, v);
        check("R6 cmh write", d, 8'h3C);
        cpu_write(6'h00, 8'h0D);            // sel 01 stream 5
        cpu_write(6'h26, 8'h77);
        cpu_read(6'h26, d, v);
        check("R6 dm write ignored", d, dm_init(5*32+6));
    endtask

    task automatic t_sel_none();
        logic [7:0] d; logic v;
        cpu_write(6'h00, 8'h06);            // sel 00 stream 6
        cpu_read(6'h21, d, v);
        check("R7 none read zero", d, 8'h00);
        cpu_write(6'h21, 8'hEE);
        cpu_write(6'h00, 8'h16);
        cpu_read(6'h21, d, v);
        check("R7 cml untouched", d, cml_init(6*32+1));
        cpu_write(6'h00, 8'h1E);
        cpu_read(6'h21, d, v);
        check("R7 cmh untouched", d, cmh_init(6*32+1));
    endtask

    task automatic t_split();
        logic [7:0] d; logic v;
        cpu_write(6'h00, 8'h9A);            // split, sel 11, stream 2
        cpu_read(6'h29, d, v);
        check("R8 split reads dm", d, dm_init(2*32+9));
        cpu_write(6'h29, 8'h42);
        cpu_read(6'h29, d, v);
        check("R8 split read after write", d, dm_init(2*32+9));
        cpu_write(6'h00, 8'h1A);
        cpu_read(6'h29, d, v);
        check("R9 split write to cmh", d, 8'h42);
        cpu_write(6'h00, 8'h8A);            // split, sel 01, stream 2
        cpu_write(6'h2C, 8'h99);
        cpu_write(6'h00, 8'h12);
        cpu_read(6'h2C, d, v);
        check("R9 split default to cml", d, 8'h99);
        cpu_write(6'h00, 8'h1A);
        cpu_read(6'h2C, d, v);
        check("R9 cmh not written", d, cmh_init(2*32+12));
    endtask

    task automatic t_strobes();
        logic [7:0] d; logic v;
        cpu_write(6'h00, 8'h14);            // sel 10 stream 4
        @(negedge clk); cpu_addr = 6'h23; cpu_wdata = 8'h5E; cpu_wr = 1'b1; cpu_rd = 1'b1;
        @(negedge clk); cpu_wr = 1'b0; cpu_rd = 1'b0;
        @(posedge clk); #1 check("R10 no rvalid on rd+wr", {7'b0, cpu_rvalid}, 8'h00);
        cpu_read(6'h23, d, v);
        check("R10 rd+wr acts as write", d, 8'h5E);
        @(negedge clk); cpu_addr = 6'h23; cpu_rd = 1'b1;
        @(negedge clk); cpu_rd = 1'b0; cpu_addr = 6'h00; cpu_wdata = 8'hC7; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
        cpu_read(6'h00, d, v);
        check("R10 strobe in fetch ignored", d, 8'h14);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_paged_read();
        t_paged_write();
        t_sel_none();
        t_split();
        t_strobes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule